// File: doc/BRIEF.md
# PF-VF Mailbox Handshake Controller

This block carries short messages between one physical function (PF, function number 0) and `N_VF` virtual functions (function numbers 1 to `N_VF`). Each function owns an outgoing mailbox of `DEPTH` 32-bit words, a command register and a read-only status word. The PF also has a queue of pending source function numbers, an acknowledgement register and a target selector. All access goes through a single register port. Every request is tagged with the function number of the requester, and that function sees only its own view of the register space.

A send works as a handshake. When a send is accepted, the sender's outgoing mailbox is copied into the receiver's incoming mailbox, and the sender's mailbox is write-locked until the receiver acknowledges with a receive command. A VF always sends to the PF, and the PF's receive pops the VF off the queue. The PF sends to the function held in its target selector, and the receiving VF's receive command raises that function's bit in the PF acknowledgement register.

Register map, as word addresses per requester (`DEPTH` must be a power of two): outgoing mailbox at `0..DEPTH-1` (read/write); incoming mailbox at `DEPTH..2*DEPTH-1` (read-only); command at `2*DEPTH` (write bit 0 = send, bit 1 = receive, reads 0); status at `2*DEPTH+1`; target selector at `2*DEPTH+2` (PF only); acknowledgement at `2*DEPTH+3` (PF only, bit n = function n, write 1 to clear). Each request gets its response on the following cycle.

Top module: `pfvf_mailbox`

## Requirements
- R1: Status word layout is: bit 0 incoming-pending, bit 1 outgoing-busy, bit 2 ack-summary, bits 11:4 current source function. Bit 3 and bits 31:12 always read 0, and every function's status reads 0 after reset.
- R2: A VF send command sets that VF's outgoing-busy bit and appends its function number to the PF queue. A send from a VF whose busy bit is already set has no effect.
- R3: While a sender's mailbox is locked, a write to its outgoing mailbox leaves the contents unchanged and, with `LOCK_ERR`=1, returns `rsp_err`=1. A VF is locked while its outgoing-busy bit is set. The PF is locked while its selected target has a message pending. Unlocked writes and all reads return `rsp_err`=0.
- R4: A PF receive command removes the queue head and clears that VF's outgoing-busy bit. A PF receive with an empty queue has no effect.
- R5: The PF incoming-pending bit is 1 exactly when the queue is non-empty. The PF current-source field shows the queue head in arrival order, and shows 0 when the queue is empty.
- R6: A PF send with a target in 1..`N_VF` whose previous message is not pending sets the target's incoming-pending bit and the PF outgoing-busy bit, which reflects the selected target. A PF send with target 0, a target above `N_VF`, or a target that is still pending is ignored.
- R7: A VF receive command with a message pending clears its incoming-pending bit, clears the PF busy state for that VF and sets bit n of the acknowledgement register, where n is the VF number. A VF receive with nothing pending changes nothing.
- R8: The PF ack-summary bit is the OR of the acknowledgement register. A PF write clears exactly the acknowledgement bits written as 1.
- R9: An accepted send copies all `DEPTH` outgoing words into the receiver's incoming mailbox. The PF incoming mailbox view shows the message of the queue-head VF.
- R10: Every request gets `rsp_valid` on the next cycle. Requests from function numbers above `N_VF` change nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fn | input | FN_W | Function number of the requester |
| req_addr | input | ADDR_W | Word address in the requester's view |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Locked mailbox write was dropped |

## Verification
The bench has every VF send in a scrambled order and checks that the PF drains them in that order. On each pop it reads the whole copied message of the head. A queue that used the wrong order or allowed a duplicate entry would show a wrong source number, or a non-zero status once the queue has drained. Locked writes are tried from both sides: a design that ignored the lock would change mailbox contents and could corrupt a message before it is acknowledged. The bench also sweeps PF sends to every target, including the illegal targets 0 and `N_VF`+1, and tests the acknowledgement write-one-to-clear one bit at a time, so that a wrong target decode or a clear of the whole register shows up in the status word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        RG_OMM,
        RG_IMM,
        RG_CMD,
        RG_STAT,
        RG_TGT,
        RG_ACK,
        RG_NONE
    } region_e;

    localparam int CMD_SEND_BIT = 0;
    localparam int CMD_RECV_BIT = 1;

    typedef struct packed {
        logic [19:0] rsv_hi;
        logic [7:0]  src;
        logic        rsv3;
        logic        ack;
        logic        obusy;
        logic        ipend;
    } status_t;

    typedef struct packed {
        logic vf_send;
        logic vf_recv;
        logic pf_send;
        logic pf_recv;
    } evt_t;

    function automatic region_e decode(input int unsigned a, input int unsigned depth);
        if (a < depth)             return RG_OMM;
        else if (a < 2 * depth)    return RG_IMM;
        else if (a == 2 * depth)   return RG_CMD;
        else if (a == 2 * depth+1) return RG_STAT;
        else if (a == 2 * depth+2) return RG_TGT;
        else if (a == 2 * depth+3) return RG_ACK;
        else                       return RG_NONE;
    endfunction

    function automatic status_t pack_status(input logic ip, input logic ob,
                                            input logic ak, input logic [7:0] src);
        status_t s;
        s        = '0;
        s.ipend  = ip;
        s.obusy  = ob;
        s.ack    = ak;
        s.src    = src;
        return s;
    endfunction

endpackage

// File: rtl/mbx_srcq.sv
module mbx_srcq #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= step(wr_ptr);
            end
            if (pop) rd_ptr <= step(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> !full);  // R2
    AST_Q_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R4

endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
    import mbx_pkg::*;
#(
    parameter int NFN  = 5,
    parameter int FN_W = 8,
    parameter int FI_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  evt_t            ev,
    input  logic [FI_W-1:0] src_i,
    input  logic [FI_W-1:0] head_i,
    input  logic [FI_W-1:0] tgt_i,
    input  logic            tgt_wr,
    input  logic [FN_W-1:0] tgt_wdata,
    input  logic            ack_clr_en,
    input  logic [NFN-1:0]  ack_clr,
    output logic [NFN-1:0]  pend,
    output logic [NFN-1:0]  vout,
    output logic [NFN-1:0]  ack,
    output logic [FN_W-1:0] tgt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            vout <= '0;
            ack  <= '0;
            tgt  <= '0;
        end else begin
            if (ev.vf_send) vout[src_i]  <= 1'b1;
            if (ev.pf_recv) vout[head_i] <= 1'b0;
            if (ev.pf_send) pend[tgt_i]  <= 1'b1;
            if (ev.vf_recv) begin
                pend[src_i] <= 1'b0;
                ack[src_i]  <= 1'b1;
            end
            if (ack_clr_en) ack <= ack & ~ack_clr;
            if (tgt_wr)     tgt <= tgt_wdata;
        end
    end

    AST_VOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ev.vf_send || ev.pf_recv) |=> $stable(vout));  // R2
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ev.pf_send || ev.vf_recv) |=> $stable(pend));  // R6
    AST_ACK_ON_RECV: assert property (@(posedge clk) disable iff (rst)
        ev.vf_recv |=> (ack != '0));  // R7

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int NFN   = 5,
    parameter int DEPTH = 8,
    parameter int FI_W  = 3,
    parameter int BX_W  = 2,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             omm_we,
    input  logic [FI_W-1:0]  src_fi,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic             vf_copy,
    input  logic [BX_W-1:0]  own_box,
    input  logic             pf_copy,
    input  logic [BX_W-1:0]  tgt_box,
    input  logic [BX_W-1:0]  head_box,
    output logic [31:0]      omm_rd,
    output logic [31:0]      vfin_rd,
    output logic [31:0]      pfin_rd
);
    localparam int NVF = NFN - 1;

    logic [31:0] omm   [NFN][DEPTH];
    logic [31:0] vf_in [NVF][DEPTH];
    logic [31:0] pf_in [NVF][DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < NFN; f++)
                for (int i = 0; i < DEPTH; i++) omm[f][i] <= '0;
            for (int b = 0; b < NVF; b++)
                for (int i = 0; i < DEPTH; i++) begin
                    vf_in[b][i] <= '0;
                    pf_in[b][i] <= '0;
                end
        end else begin
            if (omm_we) omm[src_fi][idx] <= wdata;
            if (vf_copy)
                for (int i = 0; i < DEPTH; i++) pf_in[own_box][i] <= omm[src_fi][i];
            if (pf_copy)
                for (int i = 0; i < DEPTH; i++) vf_in[tgt_box][i] <= omm[0][i];
        end
    end

    assign omm_rd  = omm[src_fi][idx];
    assign vfin_rd = vf_in[own_box][idx];
    assign pfin_rd = pf_in[head_box][idx];

endmodule

// File: rtl/pfvf_mailbox.sv
module pfvf_mailbox
    import mbx_pkg::*;
#(
    parameter int N_VF     = 4,
    parameter int DEPTH    = 8,
    parameter int FN_W     = 8,
    parameter int ADDR_W   = 6,
    parameter bit LOCK_ERR = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int NFN   = N_VF + 1;
    localparam int FI_W  = $clog2(NFN);
    localparam int BX_W  = (N_VF > 1) ? $clog2(N_VF) : 1;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [FN_W-1:0] LAST_FN = FN_W'(N_VF);

    region_e          region;
    evt_t             ev;
    logic             fn_ok, is_pf, wr, cmd_wr, tgt_ok, omm_locked, omm_we, lock_drop;
    logic [FI_W-1:0]  fi, tgt_i, head_i;
    logic [BX_W-1:0]  own_box, tgt_box, head_box;
    logic [IDX_W-1:0] idx;
    logic [NFN-1:0]   pend, vout, ack;
    logic [FN_W-1:0]  tgt, q_head;
    logic             q_empty, q_full;
    logic [31:0]      omm_rd, vfin_rd, pfin_rd, rdata;
    status_t          stat;

    assign fn_ok  = (req_fn <= LAST_FN);
    assign is_pf  = (req_fn == '0);
    assign fi     = FI_W'(req_fn);
    assign region = decode(32'(req_addr), DEPTH);
    assign idx    = req_addr[IDX_W-1:0];
    assign wr     = req_valid && req_write && fn_ok;
    assign cmd_wr = wr && (region == RG_CMD);

    assign tgt_ok   = (tgt != '0) && (tgt <= LAST_FN);
    assign tgt_i    = FI_W'(tgt);
    assign head_i   = FI_W'(q_head);
    assign own_box  = BX_W'(fi - FI_W'(1));
    assign tgt_box  = BX_W'(tgt_i - FI_W'(1));
    assign head_box = BX_W'(head_i - FI_W'(1));

    always_comb begin
        ev         = '0;
        ev.vf_send = cmd_wr && req_wdata[CMD_SEND_BIT] && !is_pf && !vout[fi];
        ev.pf_send = cmd_wr && req_wdata[CMD_SEND_BIT] && is_pf && tgt_ok && !pend[tgt_i];
        ev.vf_recv = cmd_wr && req_wdata[CMD_RECV_BIT] && !is_pf && pend[fi];
        ev.pf_recv = cmd_wr && req_wdata[CMD_RECV_BIT] && is_pf && !q_empty;
    end

    assign omm_locked = is_pf ? (tgt_ok && pend[tgt_i]) : vout[fi];
    assign omm_we     = wr && (region == RG_OMM) && !omm_locked;
    assign lock_drop  = wr && (region == RG_OMM) && omm_locked;

    mbx_srcq #(.DEPTH(N_VF), .W(FN_W)) u_srcq (
        .clk(clk), .rst(rst),
        .push(ev.vf_send), .push_data(req_fn), .pop(ev.pf_recv),
        .head(q_head), .empty(q_empty), .full(q_full)
    );

    mbx_flags #(.NFN(NFN), .FN_W(FN_W), .FI_W(FI_W)) u_flags (
        .clk(clk), .rst(rst), .ev(ev),
        .src_i(fi), .head_i(head_i), .tgt_i(tgt_i),
        .tgt_wr(wr && (region == RG_TGT) && is_pf), .tgt_wdata(req_wdata[FN_W-1:0]),
        .ack_clr_en(wr && (region == RG_ACK) && is_pf), .ack_clr(req_wdata[NFN-1:0]),
        .pend(pend), .vout(vout), .ack(ack), .tgt(tgt)
    );

    mbx_store #(.NFN(NFN), .DEPTH(DEPTH), .FI_W(FI_W), .BX_W(BX_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .omm_we(omm_we), .src_fi(fi), .idx(idx), .wdata(req_wdata),
        .vf_copy(ev.vf_send), .own_box(own_box),
        .pf_copy(ev.pf_send), .tgt_box(tgt_box), .head_box(head_box),
        .omm_rd(omm_rd), .vfin_rd(vfin_rd), .pfin_rd(pfin_rd)
    );

    always_comb begin
        if (is_pf)
            stat = pack_status(!q_empty, tgt_ok && pend[tgt_i], |ack,
                               q_empty ? 8'd0 : 8'(q_head));
        else
            stat = pack_status(pend[fi], vout[fi], 1'b0, 8'd0);
    end

    always_comb begin
        unique case (region)
            RG_OMM:  rdata = omm_rd;
            RG_IMM:  rdata = is_pf ? (q_empty ? 32'd0 : pfin_rd) : vfin_rd;
            RG_STAT: rdata = stat;
            RG_TGT:  rdata = is_pf ? 32'(tgt) : 32'd0;
            RG_ACK:  rdata = is_pf ? 32'(ack) : 32'd0;
            default: rdata = 32'd0;
        endcase
        if (!fn_ok) rdata = 32'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rdata : 32'd0;
            rsp_err   <= LOCK_ERR && lock_drop;
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R10
    AST_NO_ERR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> !rsp_err);  // R3
    AST_Q_HEAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !q_empty |-> vout[head_i]);  // R5

endmodule

// File: tb/pfvf_mailbox_tb.sv
module pfvf_mailbox_tb;
    localparam int NV = 4;
    localparam int D  = 8;
    localparam int A_IMM = D, A_CMD = 2*D, A_STAT = 2*D+1, A_TGT = 2*D+2, A_ACK = 2*D+3;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [7:0]  req_fn = 0;
    logic [5:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    pfvf_mailbox u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_fn(req_fn), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] st(input bit i, input bit o, input bit a, input int src);
        return {20'd0, 8'(src), 1'b0, a, o, i};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input int fn, input bit w, input int addr, input logic [31:0] d,
                       output logic [31:0] q, output logic e, output logic v);
        @(negedge clk);
        req_valid = 1; req_write = w; req_fn = 8'(fn); req_addr = 6'(addr); req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        q = rsp_rdata; e = rsp_err; v = rsp_valid;
    endtask

    task automatic wr(input int fn, input int addr, input logic [31:0] d, output logic e);
        logic [31:0] q; logic v;
        acc(fn, 1, addr, d, q, e, v);
    endtask

    task automatic rdchk(input int fn, input int addr, input logic [31:0] exp, input string req);
        logic [31:0] q; logic e, v;
        acc(fn, 0, addr, 0, q, e, v);
        chk(q === exp && v === 1'b1 && e === 1'b0, req, q, exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int order [4] = '{3, 1, 4, 2};
        logic e;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 / R10: reset state and out-of-range requester
        for (int f = 0; f <= NV; f++) rdchk(f, A_STAT, 0, "R1 reset status");
        rdchk(7, A_STAT, 0, "R10 bad fn reads zero");
        wr(7, A_CMD, 1, e);
        rdchk(0, A_STAT, 0, "R10 bad fn send ignored");

        // R2: VF messages and sends
        for (int v = 1; v <= NV; v++)
            for (int i = 0; i < D; i++) wr(v, i, 32'h1000_0000 + v*256 + i, e);
        for (int k = 0; k < NV; k++) begin
            wr(order[k], A_CMD, 1, e);
            rdchk(order[k], A_STAT, st(0, 1, 0, 0), "R2 vf busy after send");
        end
        wr(3, A_CMD, 1, e);  // R2 repeated send, no second queue entry

        // R3: VF lock
        wr(3, 0, 32'hFFFF_FFFF, e);
        chk(e === 1'b1, "R3 locked vf write err", 32'(e), 1);
        rdchk(3, 0, 32'h1000_0300, "R3 locked vf contents kept");

        // R5 / R9 / R4: drain queue in order
        for (int k = 0; k < NV; k++) begin
            rdchk(0, A_STAT, st(1, 0, 0, order[k]), "R5 pf head source");
            for (int i = 0; i < D; i++)
                rdchk(0, A_IMM + i, 32'h1000_0000 + order[k]*256 + i, "R9 pf incoming copy");
            wr(0, A_CMD, 2, e);
            rdchk(order[k], A_STAT, 0, "R4 vf acknowledged");
        end
        rdchk(0, A_STAT, 0, "R5 pf queue empty");
        wr(0, A_CMD, 2, e);
        rdchk(0, A_STAT, 0, "R4 pop on empty ignored");
        for (int v = 1; v <= NV; v++) rdchk(v, A_STAT, 0, "R4 vfs idle after drain");
        wr(3, 0, 32'h0000_ABCD, e);
        chk(e === 1'b0, "R3 unlocked write no err", 32'(e), 0);
        rdchk(3, 0, 32'h0000_ABCD, "R3 unlocked write lands");

        // R6: illegal targets
        for (int t = 0; t <= NV+1; t += NV+1) begin
            wr(0, A_TGT, t, e);
            wr(0, A_CMD, 1, e);
            for (int v = 1; v <= NV; v++) rdchk(v, A_STAT, 0, "R6 illegal target ignored");
            rdchk(0, A_STAT, 0, "R6 pf idle on illegal target");
        end

        // R6 / R7 / R8 / R9 / R3: PF sends to each target
        for (int t = 1; t <= NV; t++) begin
            wr(0, A_TGT, t, e);
            rdchk(0, A_TGT, t, "R6 target readback");
            for (int i = 0; i < D; i++) wr(0, i, 32'h2000_0000 + t*256 + i, e);
            wr(0, A_CMD, 1, e);
            rdchk(0, A_STAT, st(0, 1, 0, 0), "R6 pf busy toward target");
            rdchk(t, A_STAT, st(1, 0, 0, 0), "R6 target pending");
            for (int i = 0; i < D; i++)
                rdchk(t, A_IMM + i, 32'h2000_0000 + t*256 + i, "R9 vf incoming copy");
            wr(0, 1, 32'hDEAD_BEEF, e);
            chk(e === 1'b1, "R3 locked pf write err", 32'(e), 1);
            rdchk(0, 1, 32'h2000_0001 + t*256, "R3 locked pf contents kept");
            wr(t, A_CMD, 2, e);
            rdchk(t, A_STAT, 0, "R7 vf pending cleared");
            rdchk(0, A_STAT, st(0, 0, 1, 0), "R7 pf released with ack");
            rdchk(0, A_ACK, 32'(1) << t, "R7 ack bit set");
            wr(0, A_ACK, 32'(1) << t, e);
            rdchk(0, A_ACK, 0, "R8 ack cleared");
            rdchk(0, A_STAT, 0, "R8 ack summary low");
        end

        // R8: partial clear
        for (int t = 1; t <= 2; t++) begin
            wr(0, A_TGT, t, e);
            wr(0, A_CMD, 1, e);
            wr(t, A_CMD, 2, e);
        end
        rdchk(0, A_ACK, 32'h6, "R8 two ack bits");
        wr(0, A_ACK, 32'h2, e);
        rdchk(0, A_ACK, 32'h4, "R8 partial clear");
        rdchk(0, A_STAT, st(0, 0, 1, 0), "R8 summary with one bit");
        wr(0, A_ACK, 32'h4, e);

        // R7: receive with nothing pending
        wr(3, A_CMD, 2, e);
        rdchk(0, A_ACK, 0, "R7 idle receive no ack");
        rdchk(3, A_STAT, 0, "R7 idle receive no change");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule